// File: doc/BRIEF.md
# Limited-Pointer Directory Entry Controller

This block is the home-side coherence directory for a single memory block. It records up to five sharing nodes in hardware pointer slots and answers read requests directly while the sharer set fits in those slots. When one more distinct reader arrives than the slots can hold, the request is handed to a software trap. The slots are then drained one per accepted handshake into a full-map vector that software keeps elsewhere, and the entry switches to a mode where software owns the sharer list.

On a write, the entry counts the sharers other than the writer and loads that number into an acknowledgement counter. It issues one invalidation per cycle to those sharers. Exclusive permission goes to the writer only after the counter has fallen to zero. In the software-owned mode, a write is forwarded to the trap and software supplies the count. An exclusive owner is recalled the same way when another node asks for the block. While acknowledgements or a spill are pending, incoming requests are refused with a negative acknowledgement so that the requester retries.

Top module: `dirEntryCtrl`

## Requirements
- R1: After reset the state output `dirState` is 0 (hardware-shared, no sharers) and every message output is low. State codes: 0 hardware-shared, 1 spilling, 2 software-shared, 3 waiting for software count, 4 invalidating, 5 waiting for acknowledgements, 6 exclusive.
- R2: In state 0, a read from a node not yet recorded, with fewer than five sharers recorded, gives `rdReplyValid` with `rspNode` equal to the requester in the cycle after the request, and records the node.
- R3: A read from a node already recorded is answered the same way but takes no second slot, even when all five slots are used.
- R4: A read from a sixth distinct node in state 0 gives no reply. It gives `trapValid` with `trapWrite` 0 and `rspNode` equal to the requester in the next cycle, and the state becomes 1.
- R5: In state 1, `spillValid` presents the recorded nodes in the order they were first recorded. Each node stays stable until `spillReady` is high at a clock edge. The state becomes 2 at the edge that takes the last one.
- R6: In state 2, a read is forwarded as a trap with `trapWrite` 0 and the state stays 2. A write is forwarded with `trapWrite` 1 and the state becomes 3. A `swCountValid` pulse in state 3 loads `swCount` into the counter and moves to state 5.
- R7: A write in state 0 with other sharers moves to state 4. Each other sharer then gets exactly one invalidation on `invValid`/`invNode`, one per cycle, in the order the sharers were recorded. The writer gets none.
- R8: Grant (`grantValid`, `rspNode` = writer) comes one cycle after the cycle in which the counter is zero in state 5, never earlier. The state then becomes 6.
- R9: Any request that arrives in states 1, 3, 4 or 5 is answered in the next cycle only by `nakValid` with `rspNode` equal to the requester.
- R10: An acknowledgement that arrives while the counter is zero raises `protoErr` in the next cycle and changes neither the state nor any response.
- R11: In state 6, a write from the owner is granted in the next cycle. A request from another node invalidates the owner. After that acknowledgement the requester is granted (for a write) or sent a reply with the state returning to 0 (for a read).
- R12: A write in state 0 with no sharer other than the writer is granted in the next cycle and the state becomes 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request message present this cycle |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqNode | input | NODE_BITS | Requesting node |
| ackValid | input | 1 | One invalidation acknowledgement this cycle |
| swCountValid | input | 1 | Software supplies the acknowledgement count |
| swCount | input | NODE_BITS+1 | Number of acknowledgements software expects |
| spillReady | input | 1 | Full-map side takes the presented pointer |
| rdReplyValid | output | 1 | Hardware read reply |
| nakValid | output | 1 | Request refused, retry later |
| grantValid | output | 1 | Write permission granted |
| trapValid | output | 1 | Request forwarded to software |
| trapWrite | output | 1 | Forwarded request is a write |
| rspNode | output | NODE_BITS | Destination of reply, refusal, grant or trap |
| invValid | output | 1 | Invalidation message present |
| invNode | output | NODE_BITS | Node to invalidate |
| spillValid | output | 1 | Pointer offered to the full-map side |
| spillNode | output | NODE_BITS | Offered pointer |
| protoErr | output | 1 | Unexpected acknowledgement seen |
| dirState | output | 3 | Current state code (see R1) |

## Verification
The bench builds the entry with its default five slots and six-bit node numbers. With only five slots, every sharer count from zero to full can be tried with the writer either absent or at each slot position. The invalidation order, the counter load and the point of grant are therefore covered for all 21 combinations. The small slot count also makes the overflow trap, the ordered spill with back-pressure and the software-count path reachable in a few dozen cycles.

// File: rtl/dirPkg.sv
package dirPkg;

  typedef enum logic [2:0] {
    stShared     = 3'd0,
    stSpill      = 3'd1,
    stSoftShared = 3'd2,
    stSoftWait   = 3'd3,
    stInval      = 3'd4,
    stAckWait    = 3'd5,
    stExcl       = 3'd6
  } dirStateE;

  typedef enum logic [2:0] {
    rspNone  = 3'd0,
    rspReply = 3'd1,
    rspNak   = 3'd2,
    rspGrant = 3'd3,
    rspTrap  = 3'd4
  } rspKindE;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic    allocPtr;    // record requester in lowest free slot
    logic    clearMatch;  // drop requester's slot
    logic    clearLowest; // drop lowest occupied slot
    logic    setOwner;    // keep only slot 0, holding the owner
    logic    loadHw;      // counter <= sharers other than requester
    logic    loadSw;      // counter <= software count
    logic    decCnt;      // one acknowledgement consumed
    logic    latchPend;   // remember requester and kind
    logic    flagErr;     // stray acknowledgement
    rspKindE rspKind;
    logic    rspUsePend;  // message goes to pending node, not requester
    logic    rspWrite;    // trap carries a write
  } dirStrobeT;

endpackage

// File: rtl/dirDatapath.sv
module dirDatapath
  import dirPkg::*;
#(
  parameter int NUM_PTRS  = 5,
  parameter int NODE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dirStrobeT            strobe,
  input  logic [NODE_BITS-1:0] reqNode,
  input  logic                 reqWrite,
  input  logic [NODE_BITS:0]   swCount,
  output logic                 hit,
  output logic                 full,
  output logic                 anyValid,
  output logic                 lastValid,
  output logic                 othersZero,
  output logic                 cntZero,
  output logic                 pendWrite,
  output logic [NODE_BITS-1:0] lowNode,
  output logic [NODE_BITS-1:0] pendNode,
  output logic                 rdReplyValid,
  output logic                 nakValid,
  output logic                 grantValid,
  output logic                 trapValid,
  output logic                 trapWrite,
  output logic                 protoErr,
  output logic [NODE_BITS-1:0] rspNode
);

  localparam int CNT_W  = NODE_BITS + 1;
  localparam int SLOT_W = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1;
  localparam int POP_W  = $clog2(NUM_PTRS + 1);

  logic [NUM_PTRS-1:0]  ptrValid;
  logic [NODE_BITS-1:0] ptrNode [NUM_PTRS];
  logic [NUM_PTRS-1:0]  matchVec;
  logic [SLOT_W-1:0]    lowSlot, freeSlot;
  logic                 lowFound, freeFound;
  logic [POP_W-1:0]     validCount;
  logic [CNT_W-1:0]     otherCount;
  logic [CNT_W-1:0]     ackCnt;

  for (genvar g = 0; g < NUM_PTRS; g++) begin : gMatch
    assign matchVec[g] = ptrValid[g] && (ptrNode[g] == reqNode);
  end

  always_comb begin
    lowSlot    = '0;
    freeSlot   = '0;
    lowFound   = 1'b0;
    freeFound  = 1'b0;
    validCount = '0;
    otherCount = '0;
    for (int i = 0; i < NUM_PTRS; i++) begin
      if (ptrValid[i] && !lowFound) begin
        lowSlot  = SLOT_W'(i);
        lowFound = 1'b1;
      end
      if (!ptrValid[i] && !freeFound) begin
        freeSlot  = SLOT_W'(i);
        freeFound = 1'b1;
      end
      if (ptrValid[i]) validCount = validCount + POP_W'(1);
      if (ptrValid[i] && !matchVec[i]) otherCount = otherCount + CNT_W'(1);
    end
  end

  assign lowNode    = ptrNode[lowSlot];
  assign hit        = |matchVec;
  assign anyValid   = |ptrValid;
  assign full       = (validCount == POP_W'(NUM_PTRS));
  assign lastValid  = (validCount == POP_W'(1));
  assign othersZero = (otherCount == '0);
  assign cntZero    = (ackCnt == '0);

  // sharer slots
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrValid <= '0;
    end else if (strobe.setOwner) begin
      ptrValid   <= NUM_PTRS'(1);
      ptrNode[0] <= strobe.rspUsePend ? pendNode : reqNode;
    end else begin
      if (strobe.clearMatch) ptrValid <= ptrValid & ~matchVec;
      if (strobe.clearLowest) ptrValid[lowSlot] <= 1'b0;
      if (strobe.allocPtr) begin
        ptrValid[freeSlot] <= 1'b1;
        ptrNode[freeSlot]  <= reqNode;
      end
    end
  end

  // acknowledgement counter and pending request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackCnt    <= '0;
      pendNode  <= '0;
      pendWrite <= 1'b0;
    end else begin
      if (strobe.loadHw)      ackCnt <= otherCount;
      else if (strobe.loadSw) ackCnt <= swCount;
      else if (strobe.decCnt) ackCnt <= ackCnt - CNT_W'(1);
      if (strobe.latchPend) begin
        pendNode  <= reqNode;
        pendWrite <= reqWrite;
      end
    end
  end

  // registered message outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReplyValid <= 1'b0;
      nakValid     <= 1'b0;
      grantValid   <= 1'b0;
      trapValid    <= 1'b0;
      trapWrite    <= 1'b0;
      protoErr     <= 1'b0;
      rspNode      <= '0;
    end else begin
      rdReplyValid <= (strobe.rspKind == rspReply);
      nakValid     <= (strobe.rspKind == rspNak);
      grantValid   <= (strobe.rspKind == rspGrant);
      trapValid    <= (strobe.rspKind == rspTrap);
      trapWrite    <= (strobe.rspKind == rspTrap) && strobe.rspWrite;
      protoErr     <= strobe.flagErr;
      if (strobe.rspKind != rspNone)
        rspNode <= strobe.rspUsePend ? pendNode : reqNode;
    end
  end

endmodule

// File: rtl/dirControl.sv
module dirControl
  import dirPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      ackValid,
  input  logic      swCountValid,
  input  logic      spillReady,
  input  logic      hit,
  input  logic      full,
  input  logic      anyValid,
  input  logic      lastValid,
  input  logic      othersZero,
  input  logic      cntZero,
  input  logic      pendWrite,
  output dirStrobeT strobe,
  output dirStateE  curState
);

  dirStateE nextState;

  always_comb begin
    strobe    = '0;
    nextState = curState;

    if (ackValid) begin
      if (cntZero) strobe.flagErr = 1'b1;
      else         strobe.decCnt  = 1'b1;
    end

    unique case (curState)
      stShared: begin
        if (reqValid && !reqWrite) begin
          if (hit || !full) begin
            strobe.rspKind  = rspReply;
            strobe.allocPtr = !hit;
          end else begin
            strobe.rspKind = rspTrap;
            nextState      = stSpill;
          end
        end else if (reqValid) begin
          if (othersZero) begin
            strobe.rspKind  = rspGrant;
            strobe.setOwner = 1'b1;
            nextState       = stExcl;
          end else begin
            strobe.loadHw     = 1'b1;
            strobe.clearMatch = 1'b1;
            strobe.latchPend  = 1'b1;
            nextState         = stInval;
          end
        end
      end

      stExcl: begin
        if (reqValid && hit) begin
          if (reqWrite) begin
            strobe.rspKind = rspGrant;
          end else begin
            strobe.rspKind = rspReply;
            nextState      = stShared;
          end
        end else if (reqValid) begin
          strobe.loadHw    = 1'b1;
          strobe.latchPend = 1'b1;
          nextState        = stInval;
        end
      end

      stSpill: begin
        if (reqValid) strobe.rspKind = rspNak;
        if (spillReady && anyValid) begin
          strobe.clearLowest = 1'b1;
          if (lastValid) nextState = stSoftShared;
        end
      end

      stSoftShared: begin
        if (reqValid) begin
          strobe.rspKind  = rspTrap;
          strobe.rspWrite = reqWrite;
          if (reqWrite) begin
            strobe.latchPend = 1'b1;
            nextState        = stSoftWait;
          end
        end
      end

      stSoftWait: begin
        if (reqValid) strobe.rspKind = rspNak;
        if (swCountValid) begin
          strobe.loadSw = 1'b1;
          strobe.decCnt = 1'b0;
          nextState     = stAckWait;
        end
      end

      stInval: begin
        if (reqValid) strobe.rspKind = rspNak;
        if (anyValid) begin
          strobe.clearLowest = 1'b1;
          if (lastValid) nextState = stAckWait;
        end
      end

      stAckWait: begin
        if (reqValid) begin
          strobe.rspKind = rspNak;
        end else if (cntZero) begin
          strobe.rspKind    = pendWrite ? rspGrant : rspReply;
          strobe.rspUsePend = 1'b1;
          strobe.setOwner   = 1'b1;
          nextState         = pendWrite ? stExcl : stShared;
        end
      end

      default: nextState = stShared;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= stShared;
    else       curState <= nextState;
  end

endmodule

// File: rtl/dirEntryCtrl.sv
module dirEntryCtrl
  import dirPkg::*;
#(
  parameter int NUM_PTRS  = 5,
  parameter int NODE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [NODE_BITS-1:0] reqNode,
  input  logic                 ackValid,
  input  logic                 swCountValid,
  input  logic [NODE_BITS:0]   swCount,
  input  logic                 spillReady,
  output logic                 rdReplyValid,
  output logic                 nakValid,
  output logic                 grantValid,
  output logic                 trapValid,
  output logic                 trapWrite,
  output logic [NODE_BITS-1:0] rspNode,
  output logic                 invValid,
  output logic [NODE_BITS-1:0] invNode,
  output logic                 spillValid,
  output logic [NODE_BITS-1:0] spillNode,
  output logic                 protoErr,
  output logic [2:0]           dirState
);

  dirStrobeT            strobe;
  dirStateE             curState;
  logic                 hit, full, anyValid, lastValid, othersZero, cntZero, pendWrite;
  logic [NODE_BITS-1:0] lowNode, pendNode;

  dirControl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ackValid(ackValid), .swCountValid(swCountValid), .spillReady(spillReady),
    .hit(hit), .full(full), .anyValid(anyValid), .lastValid(lastValid),
    .othersZero(othersZero), .cntZero(cntZero), .pendWrite(pendWrite),
    .strobe(strobe), .curState(curState)
  );

  dirDatapath #(.NUM_PTRS(NUM_PTRS), .NODE_BITS(NODE_BITS)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqNode(reqNode),
    .reqWrite(reqWrite), .swCount(swCount), .hit(hit), .full(full),
    .anyValid(anyValid), .lastValid(lastValid), .othersZero(othersZero),
    .cntZero(cntZero), .pendWrite(pendWrite), .lowNode(lowNode),
    .pendNode(pendNode), .rdReplyValid(rdReplyValid), .nakValid(nakValid),
    .grantValid(grantValid), .trapValid(trapValid), .trapWrite(trapWrite),
    .protoErr(protoErr), .rspNode(rspNode)
  );

  assign invValid   = (curState == stInval) && anyValid;
  assign invNode    = lowNode;
  assign spillValid = (curState == stSpill) && anyValid;
  assign spillNode  = lowNode;
  assign dirState   = curState;

endmodule

// File: rtl/dirEntryChecker.sv
module dirEntryChecker #(
  parameter int NODE_BITS = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           dirState,
  input logic                 rdReplyValid,
  input logic                 nakValid,
  input logic                 grantValid,
  input logic                 trapValid,
  input logic                 trapWrite,
  input logic                 invValid,
  input logic [NODE_BITS-1:0] invNode,
  input logic [NODE_BITS-1:0] pendNode,
  input logic                 spillValid,
  input logic                 spillReady,
  input logic [NODE_BITS-1:0] spillNode,
  input logic                 cntZero,
  input logic                 ackValid,
  input logic                 protoErr
);

  assert_one_msg_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReplyValid, nakValid, grantValid, trapValid}));

  assert_nak_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    nakValid |-> ($past(dirState) == 3'd1 || $past(dirState) == 3'd3 ||
                  $past(dirState) == 3'd4 || $past(dirState) == 3'd5));

  assert_grant_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(cntZero));

  assert_inv_skip_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invNode != pendNode));

  assert_spill_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (spillValid && !spillReady) |=> (spillValid && $stable(spillNode)));

  assert_trap_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !trapWrite) |-> ($past(dirState) == 3'd0 || $past(dirState) == 3'd2));

  assert_err_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> ($past(ackValid) && $past(cntZero)));

endmodule

bind dirEntryCtrl dirEntryChecker #(.NODE_BITS(NODE_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .dirState(dirState), .rdReplyValid(rdReplyValid),
  .nakValid(nakValid), .grantValid(grantValid), .trapValid(trapValid),
  .trapWrite(trapWrite), .invValid(invValid), .invNode(invNode),
  .pendNode(pendNode), .spillValid(spillValid), .spillReady(spillReady),
  .spillNode(spillNode), .cntZero(cntZero), .ackValid(ackValid),
  .protoErr(protoErr)
);

// File: tb/dirEntryCtrl_tb.sv
`timescale 1ns/1ps
module dirEntryCtrl_tb_top;

  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqWrite, ackValid, swCountValid, spillReady;
  logic [NB-1:0] reqNode;
  logic [NB:0]   swCount;
  logic          rdReplyValid, nakValid, grantValid, trapValid, trapWrite;
  logic          invValid, spillValid, protoErr;
  logic [NB-1:0] rspNode, invNode, spillNode;
  logic [2:0]    dirState;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dirEntryCtrl #(.NUM_PTRS(5), .NODE_BITS(NB)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqNode(reqNode), .ackValid(ackValid), .swCountValid(swCountValid),
    .swCount(swCount), .spillReady(spillReady), .rdReplyValid(rdReplyValid),
    .nakValid(nakValid), .grantValid(grantValid), .trapValid(trapValid),
    .trapWrite(trapWrite), .rspNode(rspNode), .invValid(invValid),
    .invNode(invNode), .spillValid(spillValid), .spillNode(spillNode),
    .protoErr(protoErr), .dirState(dirState)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 0; reqWrite = 0; reqNode = '0; ackValid = 0;
    swCountValid = 0; swCount = '0; spillReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendReq(input bit wr, input int node);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqNode = NB'(node);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic sendAck();
    @(negedge clk);
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  function automatic int nodeOf(input int i);
    return (i * 11 + 5) % 64;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    checkEq("R1 state after reset", dirState, 0);
    checkEq("R1 outputs after reset",
            {rdReplyValid, nakValid, grantValid, trapValid, invValid, spillValid, protoErr}, 0);

    // sweep: sharer count 0..5, writer absent or at each slot
    for (int k = 0; k <= 5; k++) begin
      for (int w = -1; w < k; w++) begin
        int writer;
        int others;
        writer = (w < 0) ? 60 : nodeOf(w);
        others = (w < 0) ? k : k - 1;
        doReset();
        for (int i = 0; i < k; i++) begin
          sendReq(1'b0, nodeOf(i));
          checkEq("R2 read reply", rdReplyValid, 1);
          checkEq("R2 reply node", rspNode, nodeOf(i));
        end
        if (k > 0) begin
          sendReq(1'b0, nodeOf(0));
          checkEq("R3 repeat read reply", rdReplyValid, 1);
          checkEq("R3 repeat read no trap", trapValid, 0);
        end
        sendReq(1'b1, writer);
        if (others == 0) begin
          checkEq("R12 immediate grant", grantValid, 1);
          checkEq("R12 grant node", rspNode, writer);
          checkEq("R12 state exclusive", dirState, 6);
        end else begin
          checkEq("R7 state invalidating", dirState, 4);
          for (int i = 0; i < k; i++) begin
            if (i != w) begin
              checkEq("R7 inv valid", invValid, 1);
              checkEq("R7 inv node", invNode, nodeOf(i));
              @(negedge clk);
            end
          end
          checkEq("R7 no extra inv", invValid, 0);
          checkEq("R7 state ack wait", dirState, 5);
          sendReq(1'b0, 40);
          checkEq("R9 nak during acks", nakValid, 1);
          checkEq("R9 nak node", rspNode, 40);
          checkEq("R9 no reply on nak", rdReplyValid, 0);
          for (int a = 0; a < others; a++) begin
            sendAck();
            checkEq("R8 no early grant", grantValid, 0);
          end
          @(negedge clk);
          checkEq("R8 grant after last ack", grantValid, 1);
          checkEq("R8 grant node", rspNode, writer);
          checkEq("R8 state exclusive", dirState, 6);
        end
      end
    end

    // exclusive owner behaviour and stray acknowledgement
    doReset();
    sendReq(1'b1, 2);
    checkEq("R12 grant on empty entry", grantValid, 1);
    sendAck();
    checkEq("R10 stray ack flagged", protoErr, 1);
    checkEq("R10 stray ack no grant", grantValid, 0);
    checkEq("R10 state unchanged", dirState, 6);
    sendReq(1'b1, 2);
    checkEq("R11 owner rewrite grant", grantValid, 1);
    checkEq("R11 owner rewrite node", rspNode, 2);
    sendReq(1'b0, 9);
    checkEq("R11 recall state", dirState, 4);
    checkEq("R11 recall inv valid", invValid, 1);
    checkEq("R11 recall inv node", invNode, 2);
    @(negedge clk);
    checkEq("R11 waiting ack", dirState, 5);
    sendAck();
    checkEq("R11 no early reply", rdReplyValid, 0);
    @(negedge clk);
    checkEq("R11 reply after recall", rdReplyValid, 1);
    checkEq("R11 reply node", rspNode, 9);
    checkEq("R11 state shared", dirState, 0);
    sendReq(1'b1, 3);
    checkEq("R11 write from other invalidates", invNode, 9);
    @(negedge clk);
    sendAck();
    @(negedge clk);
    checkEq("R11 write grant", grantValid, 1);
    checkEq("R11 write grant node", rspNode, 3);

    // overflow, spill, software path
    doReset();
    for (int i = 0; i < 5; i++) sendReq(1'b0, 10 + i);
    sendReq(1'b0, 15);
    checkEq("R4 overflow trap", trapValid, 1);
    checkEq("R4 trap is read", trapWrite, 0);
    checkEq("R4 trap node", rspNode, 15);
    checkEq("R4 no reply", rdReplyValid, 0);
    checkEq("R4 state spilling", dirState, 1);
    checkEq("R5 first spill offered", spillNode, 10);
    @(negedge clk);
    checkEq("R5 spill held", spillValid, 1);
    checkEq("R5 spill node held", spillNode, 10);
    sendReq(1'b0, 30);
    checkEq("R9 nak during spill", nakValid, 1);
    for (int j = 0; j < 5; j++) begin
      checkEq("R5 spill valid", spillValid, 1);
      checkEq("R5 spill order", spillNode, 10 + j);
      spillReady = 1'b1;
      @(negedge clk);
    end
    spillReady = 1'b0;
    checkEq("R5 spill drained", spillValid, 0);
    checkEq("R5 state software shared", dirState, 2);
    sendReq(1'b0, 20);
    checkEq("R6 read trapped", trapValid, 1);
    checkEq("R6 read trap kind", trapWrite, 0);
    checkEq("R6 state stays", dirState, 2);
    sendReq(1'b1, 21);
    checkEq("R6 write trapped", trapValid, 1);
    checkEq("R6 write trap kind", trapWrite, 1);
    checkEq("R6 state sw wait", dirState, 3);
    sendReq(1'b0, 22);
    checkEq("R9 nak in sw wait", nakValid, 1);
    @(negedge clk);
    swCountValid = 1'b1; swCount = 7'd2;
    @(negedge clk);
    swCountValid = 1'b0;
    checkEq("R6 count loaded", dirState, 5);
    sendAck();
    checkEq("R8 sw path no early grant", grantValid, 0);
    sendAck();
    checkEq("R8 sw path no early grant", grantValid, 0);
    @(negedge clk);
    checkEq("R6 sw path grant", grantValid, 1);
    checkEq("R6 sw grant node", rspNode, 21);
    checkEq("R6 state exclusive", dirState, 6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule